// File: doc/BRIEF.md
# Predictive Dead-Time Gate Sequencer

This block turns a single PWM request into two gate enables for the switches of a synchronous buck power stage: the high-side enable follows the request, and the low-side enable is its complement. Between the two enables it inserts a gap in which both are low, so the switches never conduct together. There are two gaps. One is taken when the low side turns off before the high side turns on. The other is taken when the high side turns off before the low side turns on.

Each gap has its own delay code. A gap lasts `code * STEP_TICKS + 1` clock cycles. During every gap the block watches a digital flag that reports body-diode conduction on the switch node. When that gap ends, its code is trimmed for the next time the same edge occurs. Seen conduction means the gap was too long, so the code shrinks by one. No conduction means the gap may have been too short, so the code grows by one. Both codes start at their maximum, which is the safest setting.

An enable input forces both gate enables low at once. While enable is low, both codes are frozen.

Top module: `dts_sequencer`

## Requirements
- R1: While reset is asserted both gate enables are low. With enable high, the low-side enable comes on within two cycles after reset is released (request low). The first gap of each kind then lasts its maximum code times `STEP_TICKS` plus one cycle.
- R2: When the low side is on and the request is sampled high, the low-side enable drops at that clock edge. Both enables then stay low for `code_lh * STEP_TICKS + 1` cycles, after which the high-side enable comes on.
- R3: When the high side is on and the request is sampled low, the high-side enable drops at that clock edge. Both enables then stay low for `code_hl * STEP_TICKS + 1` cycles, after which the low-side enable comes on.
- R4: At the end of a completed gap, that gap's code decreases by one if the conduction flag was high in any cycle of the gap. Otherwise it increases by one. The other gap's code is unchanged.
- R5: A code never goes below 0 or above its maximum. The maxima are `LH_RANGE_TICKS / STEP_TICKS` and `HL_RANGE_TICKS / STEP_TICKS`. A step that would cross either limit leaves the code where it is.
- R6: The two enables are never high in the same cycle. Even at code 0, at least one cycle with both low separates them.
- R7: While enable is low, both gate enables are low in the same cycle, with no clock needed. Both codes keep their values, and a gap cut short by enable going low makes no code update. When enable returns high, the side the request selects comes on at the next clock edge, without a gap.
- R8: A change of the request during a gap does not shorten that gap. The target side still comes on and stays on for at least one cycle. Only then does the reverse gap begin, if the request still calls for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low forces both enables low and freezes the codes |
| pwm_req | input | 1 | PWM request: high asks for the high side, low asks for the low side |
| diode_flag | input | 1 | Body-diode conduction seen on the switch node |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with `STEP_TICKS = 2`, `LH_RANGE_TICKS = 6` and `HL_RANGE_TICKS = 4`. This gives maximum codes of 3 and 2, and gaps of 1 to 7 and 1 to 5 cycles. With limits this small, a dozen transitions of each kind drive every code value, both saturation limits and the one-cycle minimum gap. The even step also shows that the gap length scales with the step parameter rather than with the code alone. The same setup reaches enable going low in the middle of a gap and a request reversal inside a gap.

// File: rtl/dts_pkg.sv
package dts_pkg;

   typedef enum logic [2:0] {
      PH_OFF    = 3'd0,
      PH_LS     = 3'd1,
      PH_GAP_LH = 3'd2,
      PH_HS     = 3'd3,
      PH_GAP_HL = 3'd4
   } phase_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dts_code_tracker.sv
module dts_code_tracker #(
   parameter int MAX_CODE = 3,
   parameter int CW       = $clog2(MAX_CODE + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic          shorten,
   output logic [CW-1:0] code
);
   localparam logic [CW-1:0] MAXV = CW'(MAX_CODE);

   if (MAX_CODE < 1) begin : g_bad_max
      $error("dts_code_tracker: MAX_CODE must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= MAXV;
      end else if (upd) begin
         if (shorten) begin
            if (code != '0) code <= code - CW'(1);
         end else begin
            if (code != MAXV) code <= code + CW'(1);
         end
      end
   end

   a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (code == $past(code) + CW'(1)) || (code == $past(code) - CW'(1))
              || (code == $past(code)));

   a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && shorten && code == '0) |=> code == '0);

   a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !shorten && code == MAXV) |=> code == MAXV);

   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(code));

endmodule

// File: rtl/dts_gap_timer.sv
module dts_gap_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - TW'(1);
   end

   assign done = (cnt == '0);

   a_r8_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !done);

endmodule

// File: rtl/dts_phase_fsm.sv
module dts_phase_fsm
   import dts_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en,
   input  logic   pwm_req,
   input  logic   diode_flag,
   input  logic   gap_done,
   output phase_t phase,
   output logic   enter_lh,
   output logic   enter_hl,
   output logic   upd_lh,
   output logic   upd_hl,
   output logic   shorten
);
   phase_t nxt;
   logic   seen_q;
   logic   in_gap;

   assign in_gap   = (phase == PH_GAP_LH) || (phase == PH_GAP_HL);
   assign enter_lh = en && (phase == PH_LS) && pwm_req;
   assign enter_hl = en && (phase == PH_HS) && !pwm_req;
   assign upd_lh   = en && (phase == PH_GAP_LH) && gap_done;
   assign upd_hl   = en && (phase == PH_GAP_HL) && gap_done;
   assign shorten  = seen_q || diode_flag;

   always_comb begin
      nxt = phase;
      if (!en) begin
         nxt = PH_OFF;
      end else begin
         unique case (phase)
            PH_OFF:    nxt = pwm_req ? PH_HS : PH_LS;
            PH_LS:     if (pwm_req)  nxt = PH_GAP_LH;
            PH_GAP_LH: if (gap_done) nxt = PH_HS;
            PH_HS:     if (!pwm_req) nxt = PH_GAP_HL;
            PH_GAP_HL: if (gap_done) nxt = PH_LS;
            default:   nxt = PH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_OFF;
         seen_q <= 1'b0;
      end else begin
         phase <= nxt;
         if (enter_lh || enter_hl) seen_q <= 1'b0;
         else if (in_gap)          seen_q <= seen_q || diode_flag;
      end
   end

   a_r6_hs_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HS && $past(phase) != PH_HS)
         |-> ($past(phase) == PH_GAP_LH || $past(phase) == PH_OFF));

   a_r6_ls_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LS && $past(phase) != PH_LS)
         |-> ($past(phase) == PH_GAP_HL || $past(phase) == PH_OFF));

   a_r8_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (en && in_gap && !gap_done) |=> (phase == $past(phase)));

   a_r7_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> phase == PH_OFF);

endmodule

// File: rtl/dts_sequencer.sv
module dts_sequencer
   import dts_pkg::*;
#(
   parameter int STEP_TICKS     = 1,
   parameter int LH_RANGE_TICKS = 19,
   parameter int HL_RANGE_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pwm_req,
   input  logic diode_flag,
   output logic hs_gate,
   output logic ls_gate
);
   localparam int LH_MAX    = LH_RANGE_TICKS / STEP_TICKS;
   localparam int HL_MAX    = HL_RANGE_TICKS / STEP_TICKS;
   localparam int MAXC      = max_of(LH_MAX, HL_MAX);
   localparam int CW        = $clog2(MAXC + 1);
   localparam int MAX_TICKS = MAXC * STEP_TICKS;
   localparam int TW        = $clog2(MAX_TICKS + 1);

   if (STEP_TICKS < 1) begin : g_bad_step
      $error("dts_sequencer: STEP_TICKS must be at least 1");
   end
   if (LH_RANGE_TICKS < STEP_TICKS || HL_RANGE_TICKS < STEP_TICKS) begin : g_bad_range
      $error("dts_sequencer: each range must cover at least one step");
   end

   phase_t        phase;
   logic          enter_lh, enter_hl, upd_lh, upd_hl, shorten, gap_done;
   logic [1:0]    upd_vec;
   logic [CW-1:0] code [2];
   logic [TW-1:0] load_val;

   assign upd_vec = {upd_hl, upd_lh};

   dts_phase_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .pwm_req    (pwm_req),
      .diode_flag (diode_flag),
      .gap_done   (gap_done),
      .phase      (phase),
      .enter_lh   (enter_lh),
      .enter_hl   (enter_hl),
      .upd_lh     (upd_lh),
      .upd_hl     (upd_hl),
      .shorten    (shorten)
   );

   for (genvar g = 0; g < 2; g++) begin : g_edge
      localparam int EDGE_MAX = (g == 0) ? LH_MAX : HL_MAX;
      dts_code_tracker #(.MAX_CODE(EDGE_MAX), .CW(CW)) u_code (
         .clk     (clk),
         .rst_n   (rst_n),
         .upd     (upd_vec[g]),
         .shorten (shorten),
         .code    (code[g])
      );
   end

   assign load_val = enter_lh ? TW'(int'(code[0]) * STEP_TICKS)
                              : TW'(int'(code[1]) * STEP_TICKS);

   dts_gap_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (enter_lh || enter_hl),
      .load_val (load_val),
      .done     (gap_done)
   );

   assign hs_gate = en && (phase == PH_HS);
   assign ls_gate = en && (phase == PH_LS);

   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate && ls_gate));

   a_r2_hs_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate) |-> !$past(ls_gate));

   a_r3_ls_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate) |-> !$past(hs_gate));

endmodule

// File: tb/dts_sequencer_bench.sv
module dts_sequencer_bench;
   localparam int STEP = 2;
   localparam int LHM  = 3;
   localparam int HLM  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b1;
   logic pwm_req = 1'b0;
   logic diode_flag = 1'b0;
   logic hs_gate, ls_gate;

   int total = 0;
   int fails = 0;
   int overlap = 0;
   int exp_lh = LHM;
   int exp_hl = HLM;
   bit sat_lh = 1'b0;
   bit sat_hl = 1'b0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dts_sequencer #(.STEP_TICKS(STEP), .LH_RANGE_TICKS(6), .HL_RANGE_TICKS(4)) u_dts_sequencer (
      .clk(clk), .rst_n(rst_n), .en(en), .pwm_req(pwm_req),
      .diode_flag(diode_flag), .hs_gate(hs_gate), .ls_gate(ls_gate)
   );

   always @(negedge clk) if (hs_gate && ls_gate) overlap++;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   task automatic step_code(inout int c, inout bit sat, input bit flag, input int mx);
      sat = 1'b0;
      if (flag) begin
         if (c > 0) c--; else sat = 1'b1;
      end else begin
         if (c < mx) c++; else sat = 1'b1;
      end
   endtask

   // counts negedges with both enables low until the wanted side is high
   task automatic meas_gap(input bit want_hs, output int gap);
      gap = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (want_hs ? hs_gate : ls_gate) break;
         if (!hs_gate && !ls_gate) gap++;
      end
   endtask

   task automatic go_high(input bit flag, input string tag);
      int gap;
      pwm_req = 1'b1;
      diode_flag = flag;
      meas_gap(1'b1, gap);
      diode_flag = 1'b0;
      check(gap == exp_lh * STEP + 1, tag, gap, exp_lh * STEP + 1);
      check(hs_gate && !ls_gate, "R2", {hs_gate, ls_gate}, 2);
      if (exp_lh == 0) check(gap >= 1, "R6", gap, 1);
      step_code(exp_lh, sat_lh, flag, LHM);
      repeat (3) @(negedge clk);
   endtask

   task automatic go_low(input bit flag, input string tag);
      int gap;
      pwm_req = 1'b0;
      diode_flag = flag;
      meas_gap(1'b0, gap);
      diode_flag = 1'b0;
      check(gap == exp_hl * STEP + 1, tag, gap, exp_hl * STEP + 1);
      check(ls_gate && !hs_gate, "R3", {hs_gate, ls_gate}, 1);
      if (exp_hl == 0) check(gap >= 1, "R6", gap, 1);
      step_code(exp_hl, sat_hl, flag, HLM);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
   end

   initial begin
      bit pat_lh [12] = '{0,1,1,1,1,0,0,0,0,1,0,1};
      bit pat_hl [12] = '{1,1,1,0,0,0,1,0,1,1,1,0};
      int gap;
      int hs_len;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(!hs_gate && !ls_gate, "R1", {hs_gate, ls_gate}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(ls_gate && !hs_gate, "R1", {hs_gate, ls_gate}, 1);

      // R4/R5 sweep over every code value and both limits
      for (int i = 0; i < 12; i++) begin
         go_high(pat_lh[i], (i == 0) ? "R1" : (sat_lh ? "R5" : "R4"));
         go_low(pat_hl[i], (i == 0) ? "R1" : (sat_hl ? "R5" : "R4"));
      end

      // R7: disable while high side on
      go_high(1'b0, sat_lh ? "R5" : "R4");
      @(negedge clk);
      en = 1'b0;
      #1;
      check(!hs_gate && !ls_gate, "R7", {hs_gate, ls_gate}, 0);
      repeat (3) @(negedge clk);
      check(!hs_gate && !ls_gate, "R7", {hs_gate, ls_gate}, 0);
      en = 1'b1;
      @(negedge clk);
      check(hs_gate && !ls_gate, "R7", {hs_gate, ls_gate}, 2);
      repeat (2) @(negedge clk);
      go_low(1'b0, "R7");

      // R7: disable in the middle of a gap, no update
      pwm_req = 1'b1;
      diode_flag = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(!hs_gate && !ls_gate, "R7", {hs_gate, ls_gate}, 0);
      en = 1'b0;
      diode_flag = 1'b0;
      pwm_req = 1'b0;
      repeat (2) @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      check(ls_gate && !hs_gate, "R7", {hs_gate, ls_gate}, 1);
      repeat (2) @(negedge clk);
      go_high(1'b0, "R7");
      go_low(1'b0, "R3");

      // R8: request reverses inside the gap
      pwm_req = 1'b1;
      @(negedge clk);
      gap = (!hs_gate && !ls_gate) ? 1 : 0;
      pwm_req = 1'b0;
      for (int k = 0; k < 100 && !hs_gate; k++) begin
         @(negedge clk);
         if (!hs_gate && !ls_gate) gap++;
      end
      check(gap == exp_lh * STEP + 1, "R8", gap, exp_lh * STEP + 1);
      step_code(exp_lh, sat_lh, 1'b0, LHM);
      hs_len = 0;
      for (int k = 0; k < 100 && hs_gate; k++) begin
         hs_len++;
         @(negedge clk);
      end
      check(hs_len == 1, "R8", hs_len, 1);
      gap = (!hs_gate && !ls_gate) ? 1 : 0;
      for (int k = 0; k < 100 && !ls_gate; k++) begin
         @(negedge clk);
         if (!hs_gate && !ls_gate) gap++;
      end
      check(gap == exp_hl * STEP + 1, "R8", gap, exp_hl * STEP + 1);
      step_code(exp_hl, sat_hl, 1'b0, HLM);
      repeat (3) @(negedge clk);
      go_high(1'b1, "R4");

      check(overlap == 0, "R6", overlap, 0);
      summary();
   end
endmodule